// File: doc/BRIEF.md
# USART Register Access Front End

This block is the processor-side register interface of a serial USART. A processor reaches it through an active-low chip select, active-low read and write strobes, and a select line that chooses between the data side and the control side. On the data side a write loads the transmit holding register and a read returns the last received character. On the control side a read returns a status byte. The mode word, the sync characters and the command word are all written through the same control address and cannot be read back.

A sequencer decides which register each control write reaches. After any reset the sequencer expects the mode word. In synchronous mode, one or two sync characters follow the mode word. After that, every control write is a command, until a command asks for an internal reset. The block decodes the mode fields and holds them as configuration outputs for the serial engines, which are separate blocks.

A reset pulse is accepted only if it is long enough. This keeps glitches on the reset line from clearing the configuration.

Top module: `usart_regfront`

## Requirements
- R1: While `cs_n` is high, the block ignores `wr_n` and `rd_n`: no register changes and `dout` stays 0.
- R2: A data write (`cd_sel`=0) loads `tx_data`, pulses `tx_load` for exactly one cycle and clears `tx_ready`. A one-cycle `tx_take` sets `tx_ready` again. After reset `tx_ready` is 1.
- R3: After reset, the first control write (`cd_sel`=1) is the mode word, decoded as follows:
  - bits[1:0]: baud code. 00 means synchronous; 01, 10 and 11 mean x1, x16 and x64.
  - bits[3:2]: character length, `cfg_char_bits` = 5 + code.
  - bit4: parity enable.
  - bit5: even parity.
  - bits[7:6]: stop code in async mode. In sync mode, bit6 is external sync and bit7 is single sync character.
  - In async mode `cfg_ext_sync` and `cfg_single_sync` read 0. In sync mode `cfg_stop` reads 0.
  - After reset the mode and command registers are 0.
- R4: In sync mode, the next control write after the mode word loads `sync_char_a`. If the single-sync bit is 0, one more control write loads `sync_char_b`. Only the control write after that reaches the command register.
- R5: In async mode, the control write directly after the mode word reaches the command register.
- R6: A command write with bit 6 set clears `cmd_word` to 0 and returns the sequencer to expecting a mode word.
- R7: `rst` is active high and takes effect only when it is high at `RST_MIN` (6) consecutive rising clock edges. A pulse covering 5 edges changes nothing.
- R8: A read with `cd_sel`=1 returns a status byte with this layout:
  - bit0: transmit ready
  - bit1: receive ready
  - bit2: `tx_empty`
  - bit3: `err_parity`
  - bit4: `err_overrun`
  - bit5: `err_frame`
  - bits 7:6: 0

  A read with `cd_sel`=0 returns the received byte. Outside a read, `dout` is 0.
- R9: `rx_strobe` captures `rx_byte` and sets `rx_ready`. A data read clears `rx_ready`; a status read does not. If a strobe and a data read arrive in the same cycle, the strobe wins.
- R10: If `rd_n` and `wr_n` are both low at the same time, the block ignores the access.
- R11: A strobe held low for several cycles acts once, on its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, filtered by length |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | 0 = data side, 1 = control/status side |
| din | input | DW | Write data from the processor |
| dout | output | DW | Read data to the processor |
| rx_strobe | input | 1 | Receiver delivers a character |
| rx_byte | input | DW | Received character |
| tx_take | input | 1 | Transmitter has taken the holding register |
| tx_empty | input | 1 | Transmitter shift register empty |
| err_parity | input | 1 | Parity error flag |
| err_overrun | input | 1 | Overrun error flag |
| err_frame | input | 1 | Framing error flag |
| tx_data | output | DW | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse after a data write |
| tx_ready | output | 1 | Holding register free |
| rx_ready | output | 1 | Unread received character present |
| cfg_sync | output | 1 | Synchronous mode selected |
| cfg_baud | output | 2 | Baud code from the mode word |
| cfg_char_bits | output | 4 | Character length, 5 to 8 |
| cfg_par_en | output | 1 | Parity enabled |
| cfg_par_even | output | 1 | Even parity |
| cfg_stop | output | 2 | Stop code (async only) |
| cfg_ext_sync | output | 1 | External sync (sync only) |
| cfg_single_sync | output | 1 | One sync character (sync only) |
| sync_char_a | output | DW | First sync character |
| sync_char_b | output | DW | Second sync character |
| cmd_word | output | DW | Command register |

## Verification
The bench writes all 256 mode bytes. For each one it works out how many sync characters must follow before a write lands in the command register; a sequencer that miscounts would put a sync character into `cmd_word`, or a command into a sync register. It aims reset pulses at exactly 5 and exactly 6 edges; a filter that is off by one would either keep stale configuration or let a glitch wipe it. It also holds a write strobe low for several cycles, drives read and write together, and sets a receive strobe in the same cycle as a data read. An edge detector that fires on level would advance the sequencer twice, and the wrong priority would lose a character.

// File: rtl/usart_rf_pkg.sv
`timescale 1ns/1ps
package usart_rf_pkg;

   typedef enum logic [1:0] {
      SQ_MODE  = 2'd0,
      SQ_SYNC1 = 2'd1,
      SQ_SYNC2 = 2'd2,
      SQ_CMD   = 2'd3
   } seq_e;

   // mode byte, MSB first as written by the processor
   typedef struct packed {
      logic [1:0] hi_sel;     // stop code (async) / {single, ext} (sync)
      logic       par_even;
      logic       par_en;
      logic [1:0] len_code;
      logic [1:0] baud_code;
   } mode_t;

   localparam int ST_TXRDY = 0;
   localparam int ST_RXRDY = 1;
   localparam int ST_TXEMP = 2;
   localparam int ST_PERR  = 3;
   localparam int ST_OERR  = 4;
   localparam int ST_FERR  = 5;

   localparam int CMD_IRST = 6;

endpackage

// File: rtl/usart_rf_rstfilt.sv
`timescale 1ns/1ps
module usart_rf_rstfilt #(
   parameter int RST_MIN = 6
) (
   input  logic clk,
   input  logic rst,
   output logic rst_eff
);

   generate
      if (RST_MIN <= 1) begin : g_direct
         assign rst_eff = rst;
      end else begin : g_count
         localparam int CW = $clog2(RST_MIN + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst)
               cnt <= '0;
            else if (cnt != CW'(RST_MIN))
               cnt <= cnt + 1'b1;
         end

         assign rst_eff = rst && (cnt >= CW'(RST_MIN - 1));

         // first edge of a reset pulse is never enough on its own
         assert_short_reset_ignored_R7: assert property (@(posedge clk)
            $rose(rst) |-> !rst_eff);
      end
   endgenerate

endmodule

// File: rtl/usart_rf_busdec.sv
`timescale 1ns/1ps
module usart_rf_busdec #(
   parameter int DW           = 8,
   parameter bit ACT_ON_TRAIL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_eff,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          cd_sel,
   input  logic [DW-1:0] din,
   output logic          wr_evt,
   output logic          rd_evt,
   output logic          evt_cd,
   output logic [DW-1:0] evt_din,
   output logic          rd_lvl
);

   logic sel_wr, sel_rd;
   logic sel_wr_q, sel_rd_q;

   // a strobe counts only alone and only with chip select low
   assign sel_wr = !cs_n && !wr_n && rd_n;
   assign sel_rd = !cs_n && !rd_n && wr_n;
   assign rd_lvl = sel_rd;

   always_ff @(posedge clk) begin
      sel_wr_q <= sel_wr;
      sel_rd_q <= sel_rd;
   end

   generate
      if (ACT_ON_TRAIL) begin : g_trail
         logic          cd_q;
         logic [DW-1:0] din_q;
         always_ff @(posedge clk) begin
            cd_q  <= cd_sel;
            din_q <= din;
         end
         assign wr_evt  = sel_wr_q && !sel_wr;
         assign rd_evt  = sel_rd_q && !sel_rd;
         assign evt_cd  = cd_q;
         assign evt_din = din_q;
      end else begin : g_lead
         assign wr_evt  = sel_wr && !sel_wr_q;
         assign rd_evt  = sel_rd && !sel_rd_q;
         assign evt_cd  = cd_sel;
         assign evt_din = din;
      end
   endgenerate

   assert_single_write_R11: assert property (@(posedge clk) disable iff (rst_eff)
      wr_evt |=> !wr_evt);
   assert_single_read_R11: assert property (@(posedge clk) disable iff (rst_eff)
      rd_evt |=> !rd_evt);

endmodule

// File: rtl/usart_rf_ctlseq.sv
`timescale 1ns/1ps
module usart_rf_ctlseq
   import usart_rf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_eff,
   input  logic          ctl_wr,
   input  logic [DW-1:0] wdat,
   output mode_t         mode_q,
   output logic [DW-1:0] sync_a,
   output logic [DW-1:0] sync_b,
   output logic [DW-1:0] cmd_q
);

   seq_e  st;
   mode_t wmode;

   assign wmode = mode_t'(wdat[7:0]);

   always_ff @(posedge clk) begin
      if (rst_eff) begin
         st     <= SQ_MODE;
         mode_q <= '0;
         sync_a <= '0;
         sync_b <= '0;
         cmd_q  <= '0;
      end else if (ctl_wr) begin
         case (st)
            SQ_MODE: begin
               mode_q <= wmode;
               st     <= (wmode.baud_code == 2'b00) ? SQ_SYNC1 : SQ_CMD;
            end
            SQ_SYNC1: begin
               sync_a <= wdat;
               st     <= mode_q.hi_sel[1] ? SQ_CMD : SQ_SYNC2;
            end
            SQ_SYNC2: begin
               sync_b <= wdat;
               st     <= SQ_CMD;
            end
            default: begin
               if (wdat[CMD_IRST]) begin
                  cmd_q <= '0;
                  st    <= SQ_MODE;
               end else begin
                  cmd_q <= wdat;
               end
            end
         endcase
      end
   end

   assert_mode_capture_R3: assert property (@(posedge clk) disable iff (rst_eff)
      (st == SQ_MODE && ctl_wr) |=> mode_q == $past(wmode));
   assert_async_to_cmd_R5: assert property (@(posedge clk) disable iff (rst_eff)
      (st == SQ_MODE && ctl_wr && wdat[1:0] != 2'b00) |=> st == SQ_CMD);
   assert_sync_first_R4: assert property (@(posedge clk) disable iff (rst_eff)
      (st == SQ_SYNC1 && ctl_wr) |=> (sync_a == $past(wdat) && $stable(cmd_q)));
   assert_irst_R6: assert property (@(posedge clk) disable iff (rst_eff)
      (st == SQ_CMD && ctl_wr && wdat[CMD_IRST]) |=> (st == SQ_MODE && cmd_q == '0));

endmodule

// File: rtl/usart_regfront.sv
`timescale 1ns/1ps
module usart_regfront
   import usart_rf_pkg::*;
#(
   parameter int DW           = 8,
   parameter int RST_MIN      = 6,
   parameter bit ACT_ON_TRAIL = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          cd_sel,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   input  logic          rx_strobe,
   input  logic [DW-1:0] rx_byte,
   input  logic          tx_take,
   input  logic          tx_empty,
   input  logic          err_parity,
   input  logic          err_overrun,
   input  logic          err_frame,
   output logic [DW-1:0] tx_data,
   output logic          tx_load,
   output logic          tx_ready,
   output logic          rx_ready,
   output logic          cfg_sync,
   output logic [1:0]    cfg_baud,
   output logic [3:0]    cfg_char_bits,
   output logic          cfg_par_en,
   output logic          cfg_par_even,
   output logic [1:0]    cfg_stop,
   output logic          cfg_ext_sync,
   output logic          cfg_single_sync,
   output logic [DW-1:0] sync_char_a,
   output logic [DW-1:0] sync_char_b,
   output logic [DW-1:0] cmd_word
);

   localparam int STAT_USED = ST_FERR + 1;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("usart_regfront: mode layout needs DW == 8");
      end
      if (RST_MIN < 1) begin : g_bad_rst
         $error("usart_regfront: RST_MIN must be at least 1");
      end
   endgenerate

   logic          rst_eff;
   logic          wr_evt, rd_evt, evt_cd, rd_lvl;
   logic [DW-1:0] evt_din;
   logic          data_wr, ctl_wr, data_rd;
   logic [DW-1:0] rx_q;
   logic [DW-1:0] status;
   mode_t         mode_q;

   usart_rf_rstfilt #(.RST_MIN(RST_MIN)) u_rst (
      .clk     (clk),
      .rst     (rst),
      .rst_eff (rst_eff)
   );

   usart_rf_busdec #(.DW(DW), .ACT_ON_TRAIL(ACT_ON_TRAIL)) u_bus (
      .clk     (clk),
      .rst_eff (rst_eff),
      .cs_n    (cs_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .cd_sel  (cd_sel),
      .din     (din),
      .wr_evt  (wr_evt),
      .rd_evt  (rd_evt),
      .evt_cd  (evt_cd),
      .evt_din (evt_din),
      .rd_lvl  (rd_lvl)
   );

   assign data_wr = wr_evt && !evt_cd;
   assign ctl_wr  = wr_evt &&  evt_cd;
   assign data_rd = rd_evt && !evt_cd;

   usart_rf_ctlseq #(.DW(DW)) u_seq (
      .clk     (clk),
      .rst_eff (rst_eff),
      .ctl_wr  (ctl_wr),
      .wdat    (evt_din),
      .mode_q  (mode_q),
      .sync_a  (sync_char_a),
      .sync_b  (sync_char_b),
      .cmd_q   (cmd_word)
   );

   // transmit holding register
   always_ff @(posedge clk) begin
      if (rst_eff) begin
         tx_data  <= '0;
         tx_load  <= 1'b0;
         tx_ready <= 1'b1;
      end else begin
         tx_load <= data_wr;
         if (data_wr) begin
            tx_data  <= evt_din;
            tx_ready <= 1'b0;
         end else if (tx_take) begin
            tx_ready <= 1'b1;
         end
      end
   end

   // receive data register
   always_ff @(posedge clk) begin
      if (rst_eff) begin
         rx_q     <= '0;
         rx_ready <= 1'b0;
      end else if (rx_strobe) begin
         rx_q     <= rx_byte;
         rx_ready <= 1'b1;
      end else if (data_rd) begin
         rx_ready <= 1'b0;
      end
   end

   always_comb begin
      status            = '0;
      status[ST_TXRDY]  = tx_ready;
      status[ST_RXRDY]  = rx_ready;
      status[ST_TXEMP]  = tx_empty;
      status[ST_PERR]   = err_parity;
      status[ST_OERR]   = err_overrun;
      status[ST_FERR]   = err_frame;
   end

   assign dout = !rd_lvl ? '0 : (cd_sel ? status : rx_q);

   // mode field decode
   assign cfg_sync        = (mode_q.baud_code == 2'b00);
   assign cfg_baud        = mode_q.baud_code;
   assign cfg_char_bits   = 4'd5 + {2'b00, mode_q.len_code};
   assign cfg_par_en      = mode_q.par_en;
   assign cfg_par_even    = mode_q.par_even;
   assign cfg_stop        = cfg_sync ? 2'b00 : mode_q.hi_sel;
   assign cfg_ext_sync    = cfg_sync & mode_q.hi_sel[0];
   assign cfg_single_sync = cfg_sync & mode_q.hi_sel[1];

   assert_status_pad_R8: assert property (@(posedge clk) disable iff (rst_eff)
      (rd_lvl && cd_sel) |-> dout[DW-1:STAT_USED] == '0);
   assert_cs_quiet_R1: assert property (@(posedge clk) disable iff (rst_eff)
      (cs_n && !rx_strobe) |=> rx_ready == $past(rx_ready));
   assert_load_pulse_R2: assert property (@(posedge clk) disable iff (rst_eff)
      tx_load |=> !tx_load);
   assert_tx_busy_R2: assert property (@(posedge clk) disable iff (rst_eff)
      data_wr |=> (!tx_ready && tx_load));
   assert_rx_set_R9: assert property (@(posedge clk) disable iff (rst_eff)
      rx_strobe |=> rx_ready);

endmodule

// File: tb/usart_regfront_tb.sv
`timescale 1ns/1ps
module usart_regfront_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_sel = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       rx_strobe = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_take = 1'b0, tx_empty = 1'b0;
   logic       err_parity = 1'b0, err_overrun = 1'b0, err_frame = 1'b0;
   logic [7:0] tx_data;
   logic       tx_load, tx_ready, rx_ready;
   logic       cfg_sync, cfg_par_en, cfg_par_even, cfg_ext_sync, cfg_single_sync;
   logic [1:0] cfg_baud, cfg_stop;
   logic [3:0] cfg_char_bits;
   logic [7:0] sync_char_a, sync_char_b, cmd_word;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   usart_regfront dut_i (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd_sel(cd_sel),
      .din(din), .dout(dout), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
      .tx_take(tx_take), .tx_empty(tx_empty), .err_parity(err_parity),
      .err_overrun(err_overrun), .err_frame(err_frame), .tx_data(tx_data),
      .tx_load(tx_load), .tx_ready(tx_ready), .rx_ready(rx_ready),
      .cfg_sync(cfg_sync), .cfg_baud(cfg_baud), .cfg_char_bits(cfg_char_bits),
      .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_stop(cfg_stop),
      .cfg_ext_sync(cfg_ext_sync), .cfg_single_sync(cfg_single_sync),
      .sync_char_a(sync_char_a), .sync_char_b(sync_char_b), .cmd_word(cmd_word)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic cd, input logic [7:0] v);
      @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; cd_sel = cd; din = v;
      @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_rd(input logic cd, output logic [7:0] v);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; cd_sel = cd;
      #1 v = dout;
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_rst(input int edges);
      @(negedge clk); rst = 1'b1;
      repeat (edges) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_mode(input string tag, input logic [7:0] m);
      logic s;
      s = (m[1:0] == 2'b00);
      chk({tag, " sync"}, cfg_sync, s);
      chk({tag, " baud"}, cfg_baud, m[1:0]);
      chk({tag, " len"}, cfg_char_bits, 5 + m[3:2]);
      chk({tag, " par"}, {cfg_par_even, cfg_par_en}, {m[5], m[4]});
      chk({tag, " stop"}, cfg_stop, s ? 2'b00 : m[7:6]);
      chk({tag, " synccfg"}, {cfg_single_sync, cfg_ext_sync}, s ? m[7:6] : 2'b00);
   endtask

   initial begin
      logic [7:0] v;
      logic [7:0] last_a, last_b;
      repeat (2) @(negedge clk);
      pulse_rst(8);

      // reset state
      chk("R2 reset tx_ready", tx_ready, 1);
      chk("R9 reset rx_ready", rx_ready, 0);
      chk("R6 reset cmd", cmd_word, 0);
      chk_mode("R3 reset mode", 8'h00);
      chk("R8 idle dout", dout, 0);

      // R1: strobes without chip select
      @(negedge clk); cs_n = 1'b1; wr_n = 1'b0; cd_sel = 1'b0; din = 8'hA5;
      repeat (3) @(negedge clk);
      chk("R1 no tx_load", tx_load, 0);
      wr_n = 1'b1; rd_n = 1'b0;
      #1 chk("R1 dout quiet", dout, 0);
      @(negedge clk); rd_n = 1'b1; cd_sel = 1'b1; wr_n = 1'b0; din = 8'h4E;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      chk("R1 tx_data kept", tx_data, 0);
      chk("R1 tx_ready kept", tx_ready, 1);
      chk_mode("R1 mode untouched", 8'h00);

      // R3/R4/R5/R6: every mode byte
      last_a = 8'h00; last_b = 8'h00;
      for (int i = 0; i < 256; i++) begin
         logic [7:0] m;
         logic [7:0] c;
         m = 8'(i);
         bus_wr(1'b1, m);
         chk_mode("R3 mode", m);
         if (m[1:0] == 2'b00) begin
            bus_wr(1'b1, m ^ 8'h5A);
            last_a = m ^ 8'h5A;
            chk("R4 sync a", sync_char_a, last_a);
            chk("R4 cmd held", cmd_word, 0);
            if (!m[7]) begin
               bus_wr(1'b1, ~m);
               last_b = ~m;
               chk("R4 sync b", sync_char_b, last_b);
               chk("R4 cmd held b", cmd_word, 0);
            end
         end
         c = (m & 8'hBF) | 8'h01;
         bus_wr(1'b1, c);
         chk("R5 cmd", cmd_word, c);
         chk("R4 sync regs kept", {sync_char_a, sync_char_b}, {last_a, last_b});
         bus_wr(1'b1, 8'h40 | m);
         chk("R6 irst clears cmd", cmd_word, 0);
      end

      // R11: long control strobe counts once (expecting mode now)
      @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; cd_sel = 1'b1; din = 8'h4E;
      repeat (4) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      chk_mode("R11 held write", 8'h4E);
      chk("R11 cmd untouched", cmd_word, 0);
      bus_wr(1'b1, 8'h05);
      chk("R5 cmd after async", cmd_word, 8'h05);

      // R7: reset length filter
      pulse_rst(5);
      chk("R7 short pulse keeps cmd", cmd_word, 8'h05);
      chk_mode("R7 short pulse keeps mode", 8'h4E);
      bus_wr(1'b1, 8'h07);
      chk("R7 still command", cmd_word, 8'h07);
      pulse_rst(6);
      chk("R7 full pulse clears cmd", cmd_word, 0);
      bus_wr(1'b1, 8'h7B);
      chk_mode("R7 mode after reset", 8'h7B);
      bus_wr(1'b1, 8'h11);
      chk("R5 cmd after 7B", cmd_word, 8'h11);

      // R2: transmit path
      for (int k = 0; k < 6; k++) begin
         logic [7:0] d;
         d = 8'(k * 37 + 3);
         @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; cd_sel = 1'b0; din = d;
         @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
         chk("R2 load pulse", tx_load, 1);
         chk("R2 busy", tx_ready, 0);
         chk("R2 data", tx_data, d);
         @(negedge clk);
         chk("R2 pulse ends", tx_load, 0);
         tx_take = 1'b1;
         @(negedge clk); tx_take = 1'b0;
         chk("R2 take sets ready", tx_ready, 1);
      end

      // R10: read and write together
      @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; cd_sel = 1'b0; din = 8'hEE;
      #1 chk("R10 dout quiet", dout, 0);
      @(negedge clk);
      chk("R10 no load", tx_load, 0);
      cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      chk("R10 tx_data kept", tx_data, 8'd188);

      // R9: receive path
      @(negedge clk); rx_strobe = 1'b1; rx_byte = 8'hC3;
      @(negedge clk); rx_strobe = 1'b0;
      chk("R9 rx_ready set", rx_ready, 1);
      bus_rd(1'b1, v);
      chk("R9 status rxrdy", v[1], 1);
      chk("R9 status read keeps", rx_ready, 1);
      bus_rd(1'b0, v);
      chk("R8 rx data", v, 8'hC3);
      chk("R9 data read clears", rx_ready, 0);
      // strobe in same cycle as data read edge
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; cd_sel = 1'b0; rx_strobe = 1'b1; rx_byte = 8'h3C;
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; rx_strobe = 1'b0;
      chk("R9 strobe wins", rx_ready, 1);
      bus_rd(1'b0, v);
      chk("R9 new byte", v, 8'h3C);

      // R8: status layout sweep
      for (int s = 0; s < 16; s++) begin
         logic [3:0] f;
         f = 4'(s);
         @(negedge clk);
         {err_frame, err_overrun, err_parity, tx_empty} = f;
         bus_rd(1'b1, v);
         chk("R8 status", v, {2'b00, f, rx_ready, tx_ready});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #800us;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule